// File: doc/BRIEF.md
# Shift-Memory Transport Delay Controller

This block delays an 8-bit sample stream by a fixed number of shift events, which models a pure transport lag. Every shift event samples the converter word on `sample_in`, writes it into a 100-word memory and presents the word that was written 100 shifts earlier on `dac_out`. The length of the lag in time is 100 divided by the shift rate. The shift rate comes from one of two sources. The first is an external single-cycle tick. The second is an internal phase-accumulator generator, whose rate is linear in `rate_word` and is scaled by 1, 10 or 100.

A three-way mode input selects the behaviour. Compute mode shifts from the selected source. Halt mode freezes the stored contents. Entering initial condition fires a fast clearing burst that pushes zeros through the whole memory. The burst always runs to its end, even when the mode changes part way through. A ring option feeds the memory output back to its input, so the memory turns into a cyclic waveform store.

Both stream edges are strobe-only. `sample_in` is taken on the clock edge where a shift happens. `out_valid` pulses for one cycle after each shift to mark a new `dac_out` word. The converters cannot stall, so neither side has back-pressure.

Top module: `tdl_transport_delay`

## Requirements
- R1: A word taken at shift n appears on `dac_out`, with `out_valid` high for one cycle, right after shift n+100. After reset the memory holds zeros, so the first 100 outputs are 0.
- R2: In compute mode (`mode` = 01) with `src_ext` = 1, each cycle with `ext_tick` high makes exactly one shift. With `src_ext` = 0, `ext_tick` has no effect.
- R3: In halt mode (`mode` = 00, and also 11) no shift occurs and no word is lost. On return to compute, the output sequence carries on from where it stopped.
- R4: In compute mode with `src_ext` = 0, N cycles after entering compute the number of shifts is floor(N·`rate_word`·M / 2^ACC_W). M is 1 for `range_sel` 00, 10 for 01, and 100 for 10 or 11. The accumulator restarts at zero each time compute is left.
- R5: With `ring_en` = 1, each shift writes the word being output back into memory and ignores `sample_in`, so the output sequence repeats every 100 shifts.
- R6: Entering initial condition (`mode` = 10) raises `clearing` one cycle later. The block then makes exactly BURST_TICKS shifts, one every BURST_DIV cycles. These shifts load zeros whatever the state of `ring_en` and `sample_in`, and `dac_out` is 0 on each of them.
- R7: Once started, the burst finishes even if the mode leaves initial condition. External and internal ticks are ignored while `clearing` is high. The first 100 shifts after the burst output 0.
- R8: While the mode stays in initial condition after the burst has ended, no shift occurs.
- R9: Reset leaves `dac_out` = 0, `out_valid` = 0 and `clearing` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 halt, 01 compute, 10 initial condition, 11 halt |
| src_ext | input | 1 | 1 selects the external tick as shift source in compute |
| ext_tick | input | 1 | External shift request, one cycle per shift |
| range_sel | input | 2 | Internal rate multiplier: 00 ×1, 01 ×10, 1x ×100 |
| rate_word | input | RATE_W | Internal rate control magnitude |
| ring_en | input | 1 | Recirculate memory output into memory input |
| sample_in | input | DATA_W | Converter word taken on each shift |
| dac_out | output | DATA_W | Delayed word for the output converter |
| out_valid | output | 1 | One-cycle pulse after each shift |
| clearing | output | 1 | High while the clearing burst runs |

## Verification
The memory pointer, the rate accumulator and the burst counters are all internal. A fault in any of them shows at the ports within a bounded number of shifts. A pointer slip misorders `dac_out` words within at most 100 shifts of the fault. A wrong accumulator increment or scale changes the number of `out_valid` pulses counted over one window of a few hundred cycles. A burst counter that ends early leaves nonzero words behind, and these show up within the first 100 shifts after the burst. A burst counter that ends late changes the pulse count and the cycle on which `clearing` falls. Gating faults show up as a single stray or missing `out_valid` on the cycle after the offending tick.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  typedef enum logic [1:0] {
    MODE_HALT    = 2'b00,
    MODE_COMPUTE = 2'b01,
    MODE_INIT    = 2'b10,
    MODE_HALT_B  = 2'b11
  } tdl_mode_e;
endpackage

// File: rtl/tdl_rate_gen.sv
module tdl_rate_gen #(
  parameter int RATE_W = 8,
  parameter int ACC_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate_word,
  input  logic [1:0]        range_sel,
  output logic              tick
);
  localparam int INC_W = RATE_W + 7;

  logic [INC_W-1:0] inc;
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  always_comb begin
    case (range_sel)
      2'b00:   inc = INC_W'(rate_word);
      2'b01:   inc = INC_W'(rate_word) * INC_W'(10);
      default: inc = INC_W'(rate_word) * INC_W'(100);
    endcase
  end

  assign sum  = {1'b0, acc} + (ACC_W + 1)'(inc);
  assign tick = run & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)   acc <= '0;
    else if (run) acc <= sum[ACC_W-1:0];
    else          acc <= '0;
  end

  // R4: a zero rate never yields a shift tick
  p_zero_rate_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_word == '0) |-> !tick);
endmodule

// File: rtl/tdl_clear_burst.sv
module tdl_clear_burst #(
  parameter int DIV   = 1000,
  parameter int TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic tick
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [DIV_W-1:0] div_cnt;
  logic [CNT_W-1:0] tick_cnt;

  assign tick = active && (div_cnt == DIV_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      div_cnt  <= '0;
      tick_cnt <= '0;
    end else if (start) begin
      active   <= 1'b1;
      div_cnt  <= '0;
      tick_cnt <= '0;
    end else if (active) begin
      if (tick) begin
        div_cnt <= '0;
        if (tick_cnt == CNT_W'(TICKS - 1)) active <= 1'b0;
        else                               tick_cnt <= tick_cnt + 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  // R6: the burst only ends after its full count of shifts
  p_burst_full_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(tick_cnt) == CNT_W'(TICKS - 1)));
endmodule

// File: rtl/tdl_delay_mem.sv
module tdl_delay_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic              clr,
  input  logic              ring,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              out_valid
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] rd, wr;

  assign rd = store[ptr];

  always_comb begin
    if (clr)       wr = '0;
    else if (ring) wr = rd;
    else           wr = din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      ptr       <= '0;
      dout      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= shift;
      if (shift) begin
        store[ptr] <= wr;
        ptr        <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
        dout       <= clr ? '0 : rd;
      end
    end
  end

  // R1: the circular pointer stays inside the 100-word window
  p_ptr_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < DEPTH);

  // R3: without a shift the pointer does not move
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(ptr));
endmodule

// File: rtl/tdl_transport_delay.sv
module tdl_transport_delay
  import tdl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 100,
  parameter int RATE_W      = 8,
  parameter int ACC_W       = 24,
  parameter int BURST_DIV   = 1000,
  parameter int BURST_TICKS = DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              src_ext,
  input  logic              ext_tick,
  input  logic [1:0]        range_sel,
  input  logic [RATE_W-1:0] rate_word,
  input  logic              ring_en,
  input  logic [DATA_W-1:0] sample_in,
  output logic [DATA_W-1:0] dac_out,
  output logic              out_valid,
  output logic              clearing
);
  tdl_mode_e mode_e;
  logic is_compute, is_init, is_halt, was_init;
  logic burst_start, burst_active, burst_tick;
  logic rate_run, rate_tick, shift;

  assign mode_e     = tdl_mode_e'(mode);
  assign is_compute = (mode_e == MODE_COMPUTE);
  assign is_init    = (mode_e == MODE_INIT);
  assign is_halt    = (mode_e == MODE_HALT) || (mode_e == MODE_HALT_B);

  always_ff @(posedge clk) begin
    if (!rst_n) was_init <= 1'b0;
    else        was_init <= is_init;
  end

  assign burst_start = is_init && !was_init;
  assign rate_run    = is_compute && !src_ext && !burst_active;

  always_comb begin
    if (burst_active)    shift = burst_tick;
    else if (is_compute) shift = src_ext ? ext_tick : rate_tick;
    else                 shift = 1'b0;
  end

  tdl_rate_gen #(.RATE_W(RATE_W), .ACC_W(ACC_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(rate_run),
    .rate_word(rate_word), .range_sel(range_sel), .tick(rate_tick)
  );

  tdl_clear_burst #(.DIV(BURST_DIV), .TICKS(BURST_TICKS)) u_burst (
    .clk(clk), .rst_n(rst_n), .start(burst_start),
    .active(burst_active), .tick(burst_tick)
  );

  tdl_delay_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .shift(shift), .clr(burst_active),
    .ring(ring_en), .din(sample_in), .dout(dac_out), .out_valid(out_valid)
  );

  assign clearing = burst_active;

  // R3: halt never produces an output word outside a burst
  p_halt_no_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_halt && !clearing) |=> !out_valid);

  // R2: with the external source picked, no tick means no shift
  p_ext_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_compute && src_ext && !ext_tick && !clearing) |=> !out_valid);

  // R6: every word emitted during the burst is zero
  p_burst_out_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clearing && out_valid) |-> (dac_out == '0));

  // R8: initial condition after the burst is idle
  p_init_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_init && was_init && !clearing) |=> !out_valid);
endmodule

// File: tb/tdl_transport_delay_test.sv
module tdl_transport_delay_test;
  localparam int ACC_W = 16;
  localparam int BDIV  = 4;
  localparam int NVEC  = 8;

  localparam int V_RATE  [NVEC] = '{200, 100, 50, 255, 0,   1,    128, 10};
  localparam int V_RANGE [NVEC] = '{0,   1,   2,  2,   2,   0,    0,   3};
  localparam int V_CYC   [NVEC] = '{1000,1000,200,300, 500, 1000, 512, 400};
  localparam int V_EXP   [NVEC] = '{3,   15,  15, 116, 0,   0,    1,   6};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       src_ext = 1'b0;
  logic       ext_tick = 1'b0;
  logic [1:0] range_sel = 2'b00;
  logic [7:0] rate_word = 8'd0;
  logic       ring_en = 1'b0;
  logic [7:0] sample_in = 8'd0;
  logic [7:0] dac_out;
  logic       out_valid;
  logic       clearing;

  int checks = 0;
  int errors = 0;
  int q[$];

  always #5 clk = ~clk;

  tdl_transport_delay #(.ACC_W(ACC_W), .BURST_DIV(BDIV)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .src_ext(src_ext),
    .ext_tick(ext_tick), .range_sel(range_sel), .rate_word(rate_word),
    .ring_en(ring_en), .sample_in(sample_in), .dac_out(dac_out),
    .out_valid(out_valid), .clearing(clearing)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    q.delete();
    for (int i = 0; i < 100; i++) q.push_back(0);
  endtask

  task automatic ext_shift(input int s, input string req);
    int exp;
    sample_in = s[7:0];
    ext_tick  = 1'b1;
    @(negedge clk);
    ext_tick  = 1'b0;
    exp = q.pop_front();
    q.push_back(ring_en ? exp : s);
    chk(req, int'(out_valid), 1);
    chk(req, int'(dac_out), exp);
  endtask

  task automatic count_pulses(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (out_valid) n++;
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9", int'(dac_out), 0);
    chk("R9", int'(out_valid), 0);
    chk("R9", int'(clearing), 0);

    // R4 internal rate vectors (memory stays zero, sample 0)
    for (int v = 0; v < NVEC; v++) begin
      mode = 2'b00;
      @(negedge clk);
      rate_word = V_RATE[v][7:0];
      range_sel = V_RANGE[v][1:0];
      src_ext   = 1'b0;
      mode      = 2'b01;
      count_pulses(V_CYC[v], n);
      mode = 2'b00;
      chk("R4", n, V_EXP[v]);
    end
    @(negedge clk);

    // R2 external tick ignored with internal source at zero rate
    rate_word = 8'd0;
    mode = 2'b01;
    src_ext = 1'b0;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      ext_tick = 1'b1;
      @(negedge clk);
      if (out_valid) n++;
    end
    ext_tick = 1'b0;
    @(negedge clk);
    if (out_valid) n++;
    chk("R2", n, 0);

    // R1/R2 fill then read back after 100 shifts
    src_ext = 1'b1;
    for (int k = 0; k < 100; k++) ext_shift(k + 1, "R1");
    for (int k = 0; k < 100; k++) ext_shift(k + 101, "R1");

    // R3 halt (both encodings) ignores ticks
    mode = 2'b00;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      ext_tick = 1'b1;
      @(negedge clk);
      if (out_valid) n++;
    end
    mode = 2'b11;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_valid) n++;
    end
    ext_tick = 1'b0;
    @(negedge clk);
    if (out_valid) n++;
    chk("R3", n, 0);
    mode = 2'b01;
    for (int k = 0; k < 10; k++) ext_shift(8'h55, "R3");

    // R5 ring recirculation
    ring_en = 1'b1;
    for (int k = 0; k < 200; k++) ext_shift(8'hEE, "R5");
    ring_en = 1'b0;

    // R6 burst from initial condition, external ticks held on (R7)
    mode = 2'b10;
    @(negedge clk);
    chk("R6", int'(clearing), 1);
    n = 0;
    for (int i = 0; i < 100 * BDIV + 10; i++) begin
      ext_tick = 1'b1;
      @(negedge clk);
      if (out_valid) begin
        n++;
        if (dac_out != 8'd0) chk("R6", int'(dac_out), 0);
      end
    end
    chk("R6", n, 100);
    chk("R6", int'(clearing), 0);
    model_clear();
    // R8 idle in initial condition after burst
    count_pulses(10, n);
    ext_tick = 1'b0;
    chk("R8", n, 0);
    mode = 2'b01;
    @(negedge clk);
    for (int k = 0; k < 100; k++) ext_shift(k + 7, "R7");

    // R7 burst finishes after early mode exit, ring ignored
    ring_en = 1'b1;
    mode = 2'b10;
    @(negedge clk);
    mode = 2'b01;
    src_ext = 1'b1;
    n = 0;
    for (int i = 0; i < 100 * BDIV + 10; i++) begin
      ext_tick = (i < 100 * BDIV - 20);
      sample_in = 8'hA5;
      @(negedge clk);
      if (out_valid) n++;
    end
    ext_tick = 1'b0;
    chk("R7", n, 100);
    chk("R7", int'(clearing), 0);
    ring_en = 1'b0;
    model_clear();
    for (int k = 0; k < 5; k++) ext_shift(8'h33, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule